// File: doc/BRIEF.md
# RISC Integer Execute Unit

This block is the execute stage of a small 32-bit load-store integer pipeline. Each cycle it may accept one decoded operation: a 6-bit primary opcode, a 6-bit function field, two 32-bit register operands and a 16-bit immediate field. From these it computes a 32-bit result and two flags. The zero flag shows whether the result is zero. The equality flag shows whether the two register operands match, and the branch unit uses it to resolve conditional branches.

The operations are register add, subtract and set-less-than, and the immediate forms add, OR, set-less-than and load-upper. Each immediate form extends the 16-bit field in its own way. Add and set-less-than sign-extend it. OR zero-extends it. Load-upper moves it into the high half. The opcode and function field are decoded together. Any combination outside the supported set raises an illegal-operation flag and gives a zero result. The outputs are registered, so they appear one clock after an accepted request.

Top module: `risc_exec_unit`

## Requirements
- R1: While reset is held low and right after it is released, out_valid, result, zero, equal and illegal are all 0.
- R2: With opcode 0, function 32 gives src_a + src_b and function 34 gives src_a - src_b. Both wrap modulo 2^32 and never set illegal.
- R3: With opcode 0 and function 42, the result is 1 when src_a < src_b as signed 32-bit integers, and 0 otherwise.
- R4: Opcode 8 gives src_a plus the immediate, sign-extended from bit 15 to 32 bits, wrapping modulo 2^32.
- R5: Opcode 10 gives 1 when src_a is less than the sign-extended immediate as signed 32-bit integers, and 0 otherwise.
- R6: Opcode 13 gives src_a OR the immediate zero-extended to 32 bits.
- R7: Opcode 15 gives the immediate in bits 31:16 with bits 15:0 zero, and src_a has no effect.
- R8: Any other opcode, or opcode 0 with a function other than 32, 34 or 42, sets illegal to 1 and makes the result 0. Supported operations set illegal to 0.
- R9: zero is 1 exactly when the registered result is 0. equal is 1 exactly when src_a equals src_b, for every opcode including illegal ones.
- R10: When in_valid is high at a rising edge, result, zero, equal and illegal take the new values at that edge and out_valid is 1 for one cycle. When in_valid is low, out_valid is 0 and the other outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| opcode | input | 6 | Primary opcode |
| funct | input | 6 | Function field, used when opcode is 0 |
| src_a | input | 32 | First register operand |
| src_b | input | 32 | Second register operand |
| imm | input | 16 | Immediate field |
| out_valid | output | 1 | Registered result is new this cycle |
| result | output | 32 | Registered result |
| zero | output | 1 | Registered result equals zero |
| equal | output | 1 | Operands were equal |
| illegal | output | 1 | Opcode/function pair unsupported |

## Verification
Random operands are applied to every supported operation. Directed cases follow, and they target the signed boundaries. Operand pairs that straddle 0x7FFFFFFF/0x80000000 separate a signed set-less-than from an unsigned one. Immediates with bit 15 set separate sign extension (add and set-less-than immediate) from zero extension (OR immediate). Load-upper is applied with a nonzero src_a to show that src_a is ignored. Sums that overflow or cancel to zero exercise the wrap-around and the zero flag. Function codes next to the legal ones and unused opcodes show that the decoder rejects them. Idle cycles between requests check that the registered outputs hold.

// File: rtl/exu_pkg.sv
package exu_pkg;
    localparam int OPC_W = 6;
    localparam int FN_W  = 6;

    localparam logic [OPC_W-1:0] OPC_REG   = 6'd0;
    localparam logic [OPC_W-1:0] OPC_ADDI  = 6'd8;
    localparam logic [OPC_W-1:0] OPC_SLTI  = 6'd10;
    localparam logic [OPC_W-1:0] OPC_ORI   = 6'd13;
    localparam logic [OPC_W-1:0] OPC_LUI   = 6'd15;

    localparam logic [FN_W-1:0]  FN_ADD = 6'd32;
    localparam logic [FN_W-1:0]  FN_SUB = 6'd34;
    localparam logic [FN_W-1:0]  FN_SLT = 6'd42;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_SLT,
        ALU_OR,
        ALU_PASS_B
    } alu_op_e;

    typedef enum logic [1:0] {
        EXT_SIGN,
        EXT_ZERO,
        EXT_UPPER
    } ext_kind_e;

    typedef struct packed {
        alu_op_e   alu_op;
        logic      use_imm;
        ext_kind_e ext_kind;
        logic      bad_op;
    } dec_t;
endpackage

// File: rtl/exu_decode.sv
module exu_decode
    import exu_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    input  logic [FN_W-1:0]  funct,
    output dec_t             dec
);
    always_comb begin
        dec          = '0;
        dec.alu_op   = ALU_ADD;
        dec.ext_kind = EXT_SIGN;
        unique case (opcode)
            OPC_REG: begin
                unique case (funct)
                    FN_ADD:  dec.alu_op = ALU_ADD;
                    FN_SUB:  dec.alu_op = ALU_SUB;
                    FN_SLT:  dec.alu_op = ALU_SLT;
                    default: dec.bad_op = 1'b1;
                endcase
            end
            OPC_ADDI: begin
                dec.alu_op  = ALU_ADD;
                dec.use_imm = 1'b1;
            end
            OPC_SLTI: begin
                dec.alu_op  = ALU_SLT;
                dec.use_imm = 1'b1;
            end
            OPC_ORI: begin
                dec.alu_op   = ALU_OR;
                dec.use_imm  = 1'b1;
                dec.ext_kind = EXT_ZERO;
            end
            OPC_LUI: begin
                dec.alu_op   = ALU_PASS_B;
                dec.use_imm  = 1'b1;
                dec.ext_kind = EXT_UPPER;
            end
            default: dec.bad_op = 1'b1;
        endcase
    end
endmodule

// File: rtl/exu_imm_ext.sv
module exu_imm_ext
    import exu_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16
) (
    input  logic [IMM_W-1:0] imm,
    input  ext_kind_e        kind,
    output logic [XLEN-1:0]  imm_ext
);
    localparam int PAD_W = XLEN - IMM_W;

    logic [XLEN-1:0] sext_w;
    logic [XLEN-1:0] zext_w;
    logic [XLEN-1:0] upper_w;

    generate
        if (PAD_W > 0) begin : g_pad
            assign sext_w  = {{PAD_W{imm[IMM_W-1]}}, imm};
            assign zext_w  = {{PAD_W{1'b0}}, imm};
            assign upper_w = {imm, {PAD_W{1'b0}}};
        end else begin : g_nopad
            assign sext_w  = imm[XLEN-1:0];
            assign zext_w  = imm[XLEN-1:0];
            assign upper_w = imm[XLEN-1:0];
        end
    endgenerate

    always_comb begin
        unique case (kind)
            EXT_ZERO:  imm_ext = zext_w;
            EXT_UPPER: imm_ext = upper_w;
            default:   imm_ext = sext_w;
        endcase
    end
endmodule

// File: rtl/exu_alu.sv
module exu_alu
    import exu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);
    logic [XLEN-1:0] sum_w;
    logic [XLEN-1:0] diff_w;
    logic            lt_w;

    assign sum_w  = a + b;
    assign diff_w = a - b;
    assign lt_w   = $signed(a) < $signed(b);

    always_comb begin
        unique case (op)
            ALU_ADD:    y = sum_w;
            ALU_SUB:    y = diff_w;
            ALU_SLT:    y = {{(XLEN-1){1'b0}}, lt_w};
            ALU_OR:     y = a | b;
            ALU_PASS_B: y = b;
            default:    y = '0;
        endcase
    end
endmodule

// File: rtl/risc_exec_unit.sv
module risc_exec_unit
    import exu_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [5:0]       opcode,
    input  logic [5:0]       funct,
    input  logic [XLEN-1:0]  src_a,
    input  logic [XLEN-1:0]  src_b,
    input  logic [IMM_W-1:0] imm,
    output logic             out_valid,
    output logic [XLEN-1:0]  result,
    output logic             zero,
    output logic             equal,
    output logic             illegal
);
    typedef struct packed {
        logic            vld;
        logic [XLEN-1:0] res;
        logic            zf;
        logic            eq;
        logic            bad;
    } stage_t;

    dec_t            dec_w;
    logic [XLEN-1:0] imm_ext_w;
    logic [XLEN-1:0] opnd_b_w;
    logic [XLEN-1:0] alu_y_w;
    logic [XLEN-1:0] res_w;
    stage_t          st_d, st_q;

    exu_decode u_dec (
        .opcode (opcode),
        .funct  (funct),
        .dec    (dec_w)
    );

    exu_imm_ext #(.XLEN(XLEN), .IMM_W(IMM_W)) u_ext (
        .imm     (imm),
        .kind    (dec_w.ext_kind),
        .imm_ext (imm_ext_w)
    );

    assign opnd_b_w = dec_w.use_imm ? imm_ext_w : src_b;

    exu_alu #(.XLEN(XLEN)) u_alu (
        .op (dec_w.alu_op),
        .a  (src_a),
        .b  (opnd_b_w),
        .y  (alu_y_w)
    );

    assign res_w = dec_w.bad_op ? '0 : alu_y_w;

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.res = res_w;
            st_d.zf  = (res_w == '0);
            st_d.eq  = (src_a == src_b);
            st_d.bad = dec_w.bad_op;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;
    assign zero      = st_q.zf;
    assign equal     = st_q.eq;
    assign illegal   = st_q.bad;

    p_illegal_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (result == '0));

    p_zero_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        zero == (result == '0) || !out_valid && $stable(zero));

    p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(illegal)));

    p_lui_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == OPC_LUI) |=> (result[IMM_W-1:0] == '0));

    p_slt_bool_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == OPC_REG && funct == FN_SLT) |=> (result[XLEN-1:1] == '0));
endmodule

// File: tb/risc_exec_unit_bench.sv
`timescale 1ns/1ps
module risc_exec_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [5:0]  opcode = '0;
    logic [5:0]  funct = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [15:0] imm = '0;
    logic        out_valid, zero, equal, illegal;
    logic [31:0] result;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    risc_exec_unit u_risc_exec_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .funct(funct), .src_a(src_a), .src_b(src_b), .imm(imm),
        .out_valid(out_valid), .result(result), .zero(zero),
        .equal(equal), .illegal(illegal)
    );

    function automatic logic [31:0] sx(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    function automatic void model(input logic [5:0] op, input logic [5:0] fn,
                                  input logic [31:0] a, input logic [31:0] b,
                                  input logic [15:0] im,
                                  output logic [31:0] r, output logic bad);
        bad = 1'b0;
        r   = '0;
        case (op)
            6'd0: case (fn)
                6'd32: r = a + b;
                6'd34: r = a - b;
                6'd42: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                default: bad = 1'b1;
            endcase
            6'd8:  r = a + sx(im);
            6'd10: r = ($signed(a) < $signed(sx(im))) ? 32'd1 : 32'd0;
            6'd13: r = a | {16'h0, im};
            6'd15: r = {im, 16'h0};
            default: bad = 1'b1;
        endcase
    endfunction

    function automatic string tag(input logic [5:0] op, input logic [5:0] fn);
        case (op)
            6'd0: case (fn)
                6'd32, 6'd34: return "R2";
                6'd42: return "R3";
                default: return "R8";
            endcase
            6'd8:  return "R4";
            6'd10: return "R5";
            6'd13: return "R6";
            6'd15: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [5:0] op, input logic [5:0] fn,
                          input logic [31:0] a, input logic [31:0] b,
                          input logic [15:0] im);
        logic [31:0] er;
        logic        eb;
        model(op, fn, a, b, im, er, eb);
        @(negedge clk);
        opcode = op; funct = fn; src_a = a; src_b = b; imm = im; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(tag(op, fn), "result", result, er);
        check("R8", "illegal", {31'b0, illegal}, {31'b0, eb});
        check("R9", "zero", {31'b0, zero}, {31'b0, er == 32'h0});
        check("R9", "equal", {31'b0, equal}, {31'b0, a == b});
        check("R10", "out_valid", {31'b0, out_valid}, 32'd1);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [5:0] ops [5];
        logic [5:0] fns [3];
        int         seed;
        ops[0] = 6'd0; ops[1] = 6'd8; ops[2] = 6'd10; ops[3] = 6'd13; ops[4] = 6'd15;
        fns[0] = 6'd32; fns[1] = 6'd34; fns[2] = 6'd42;
        seed = $urandom(32'd20240611);

        repeat (3) @(negedge clk);
        check("R1", "reset out_valid", {31'b0, out_valid}, 32'd0);
        check("R1", "reset result", result, 32'd0);
        check("R1", "reset flags", {29'b0, zero, equal, illegal}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "post-reset result", result, 32'd0);

        // R2 wrap and cancel
        run_op(6'd0, 6'd32, 32'hFFFF_FFFF, 32'd1, 16'h0);
        run_op(6'd0, 6'd34, 32'd0, 32'd1, 16'h0);
        run_op(6'd0, 6'd34, 32'h1234_5678, 32'h1234_5678, 16'h0);
        // R3 signed boundary
        run_op(6'd0, 6'd42, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0);
        run_op(6'd0, 6'd42, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0);
        run_op(6'd0, 6'd42, 32'd5, 32'd5, 16'h0);
        // R4 negative immediate
        run_op(6'd8, 6'd0, 32'd10, 32'd0, 16'hFFFF);
        run_op(6'd8, 6'd0, 32'd3, 32'd9, 16'hFFFD);
        // R5 sign-extended compare
        run_op(6'd10, 6'd0, 32'd0, 32'd0, 16'h8000);
        run_op(6'd10, 6'd0, 32'hFFFF_FFFE, 32'd0, 16'hFFFF);
        // R6 zero extension
        run_op(6'd13, 6'd0, 32'hABCD_0000, 32'd0, 16'h8001);
        // R7 src_a ignored
        run_op(6'd15, 6'd0, 32'hDEAD_BEEF, 32'd7, 16'hA5A5);
        // R8 illegal neighbours
        run_op(6'd0, 6'd33, 32'd4, 32'd4, 16'h0);
        run_op(6'd0, 6'd43, 32'd1, 32'd2, 16'h0);
        run_op(6'd9, 6'd32, 32'd1, 32'd2, 16'h1);
        run_op(6'd63, 6'd0, 32'd1, 32'd2, 16'h1);

        // R10 hold while idle
        run_op(6'd0, 6'd32, 32'd100, 32'd23, 16'h0);
        opcode = 6'd15; imm = 16'hFFFF; src_a = 32'd0; src_b = 32'd0;
        repeat (3) @(negedge clk);
        check("R10", "idle out_valid", {31'b0, out_valid}, 32'd0);
        check("R10", "idle hold result", result, 32'd123);
        check("R10", "idle hold equal", {31'b0, equal}, 32'd0);

        for (int i = 0; i < 400; i++) begin
            logic [5:0]  op;
            logic [5:0]  fn;
            logic [31:0] a, b;
            if (($urandom % 10) == 0) begin
                op = 6'($urandom);
                fn = 6'($urandom);
            end else begin
                op = ops[$urandom % 5];
                fn = fns[$urandom % 3];
            end
            a = $urandom;
            b = (($urandom % 6) == 0) ? a : $urandom;
            run_op(op, fn, a, b, 16'($urandom));
            if (($urandom % 4) == 0) @(negedge clk);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule